// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers 24 maskable interrupt request lines. Each line is caught in its own pending flag. A global enable and a per-source enable decide which pending sources are eligible. The controller picks the lowest-numbered eligible source and offers it to the CPU core. The offer consists of a valid flag, a 16-bit code-memory vector and a 5-bit source number.

The CPU takes the offer with a one-cycle acknowledge pulse. On that pulse the controller clears the pending flag of the source it was offering. Software never clears a flag itself. Once an offer is made, it is held until it is acknowledged or until its enables are withdrawn. A higher-priority request that arrives later therefore cannot switch the vector under the core.

A small register port loads the global enable and four 6-bit enable groups, and reads them back. The reset entry at vector 0x0000 is not handled here.

Top module: `prio_vec_intc`

## Requirements
- R1: After a synchronous active-low reset, all of the following are zero: every pending flag, every enable bit, the global enable, irq_valid and the read-back of every address.
- R2: A high level on req[k-1] in a clock cycle sets the pending flag of source k (1..24). The flag stays set, whether or not the source is enabled, until an acknowledge clears it.
- R3: irq_valid is high only while the global enable is 1 and the chosen source's own enable bit is 1. Enable bits sit at address 1 bits 5:0 (sources 1..6), address 2 (sources 7..12), address 3 (sources 13..18) and address 4 (sources 19..24), with bit 0 mapping to the lowest source of each group.
- R4: When no offer is being held, the controller offers the lowest-numbered source that is pending and enabled.
- R5: While irq_valid is high, irq_index equals k and irq_vector equals 0x0003 + 8*(k-1). While irq_valid is low, both read zero.
- R6: While irq_valid is high and irq_ack is low, irq_index and irq_vector keep their values in the next cycle, even if a higher-priority request arrives, as long as the offered source stays enabled.
- R7: irq_ack while irq_valid is high clears exactly the offered source's flag. In the following cycle the next eligible source, if any, is offered.
- R8: If req for the offered source is high in the same cycle as irq_ack, the flag stays set and the source is offered again.
- R9: The global enable is bit 0 of address 0. Writes to addresses 5..7 are ignored. Bits above the stored width, and addresses 5..7, read as zero.
- R10: irq_ack while irq_valid is low changes no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 24 | Request lines; bit k-1 belongs to source k |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | One-cycle accept from the CPU |
| irq_valid | output | 1 | An interrupt is being offered |
| irq_index | output | 5 | Offered source number, 1..24 |
| irq_vector | output | 16 | Offered code-memory vector address |

## Verification
A pending flag that is lost or cleared early shows up as a missing offer. The bench sees this once the matching enables are set, one cycle after the enabling write. A flag that fails to clear shows up as the same source being offered again in the cycle right after its acknowledge. A corrupted hold or priority state shows up at once on irq_index and irq_vector, in the cycle that follows a competing request.

// File: rtl/intc_pkg.sv
// Package: shared sizes for the vectored interrupt controller.
// Assumes sources are numbered from 1 and the vectors are evenly spaced.
package intc_pkg;
    parameter int NUM_SRC  = 24;
    parameter int GRP_W    = 6;
    parameter int ADDR_W   = 3;
    parameter int DATA_W   = 8;
    parameter int VEC_W    = 16;
    parameter int VEC_BASE = 3;
    parameter int VEC_STEP = 8;
    localparam int NUM_GRP = NUM_SRC / GRP_W;
    localparam int IDX_W   = $clog2(NUM_SRC + 1);
    localparam int ADDR_GLB = 0;
    localparam int ADDR_GRP0 = 1;
endpackage

// File: rtl/intc_regs.sv
// Module: enable register file. It holds the global enable and NUM_GRP
// enable groups of GRP_W bits each, and offers a combinational read-back.
// Assumes: one write per cycle; undecoded addresses ignore writes and read zero.
module intc_regs
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              glb_en,
    output logic [NUM_SRC-1:0] src_en
);
    logic [GRP_W-1:0] grp_q [NUM_GRP];
    logic unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DATA_W-1:GRP_W];

    // Global enable register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            glb_en <= 1'b0;
        else if (wr_en && wr_addr == ADDR_W'(ADDR_GLB))
            glb_en <= wr_data[0];
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        // Enable group g register update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                grp_q[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(ADDR_GRP0 + g))
                grp_q[g] <= wr_data[GRP_W-1:0];
        end
        assign src_en[g*GRP_W +: GRP_W] = grp_q[g];
    end

    // Read-back multiplexer, zero-filled above stored width.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_GLB))
            rd_data[0] = glb_en;
        for (int g = 0; g < NUM_GRP; g++)
            if (rd_addr == ADDR_W'(ADDR_GRP0 + g))
                rd_data[GRP_W-1:0] = grp_q[g];
    end

    // R9: an undecoded write leaves every enable untouched.
    a_r9_undecoded_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(ADDR_GRP0 + NUM_GRP)) |=>
            ($stable(src_en) && $stable(glb_en)));
endmodule

// File: rtl/intc_pending.sv
// Module: pending flag array. A request sets its flag and a one-hot clear
// from the selector drops it. A set in the same cycle as a clear wins.
// Assumes clr has at most one bit high.
module intc_pending
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pending
);
    // Flag update: keep, clear on acknowledge, set on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= '0;
        else
            pending <= (pending & ~clr) | req;
    end

    // R2: a set flag that was not cleared is still set.
    a_r2_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pending) & ~$past(clr)) & ~pending) == '0));

    // R8: a request always leaves its flag set, even against a clear.
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(req) & ~pending) == '0));
endmodule

// File: rtl/intc_select.sv
// Module: masking, fixed-priority choice, offer hold and vector build.
// The offer is locked once it is made, and is released by an acknowledge
// or by losing its enables. Source numbers run from 1; vectors are evenly spaced.
module intc_select
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pending,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               glb_en,
    input  logic               ack,
    output logic               valid,
    output logic [IDX_W-1:0]   index,
    output logic [VEC_W-1:0]   vector,
    output logic [NUM_SRC-1:0] clr
);
    logic [NUM_SRC-1:0] act;
    logic               win_found;
    logic [IDX_W-1:0]   win_idx;
    logic               lk_valid;
    logic [IDX_W-1:0]   lk_idx;
    logic               lk_ok;
    logic [IDX_W-1:0]   sel_idx;

    assign act   = pending & src_en & {NUM_SRC{glb_en}};
    assign lk_ok = lk_valid && act[lk_idx];

    // Lowest-numbered eligible source.
    always_comb begin
        win_found = 1'b0;
        win_idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--)
            if (act[i]) begin
                win_found = 1'b1;
                win_idx   = IDX_W'(i);
            end
    end

    // Choice of held offer versus fresh winner.
    always_comb begin
        sel_idx = lk_ok ? lk_idx : win_idx;
        valid   = lk_ok || win_found;
        index   = valid ? sel_idx + IDX_W'(1) : '0;
        vector  = valid ? VEC_W'(VEC_BASE) + VEC_W'(sel_idx) * VEC_W'(VEC_STEP) : '0;
        clr     = '0;
        if (valid && ack)
            clr[sel_idx] = 1'b1;
    end

    // Offer lock: capture while offered, release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_valid <= 1'b0;
            lk_idx   <= '0;
        end else begin
            lk_valid <= valid && !ack;
            lk_idx   <= sel_idx;
        end
    end

    // R3: an offer needs both the global and its own enable.
    a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (glb_en && src_en[index - IDX_W'(1)]));

    // R6: an unacknowledged offer does not move while it stays enabled.
    a_r6_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ack) |=> (!valid || !act[$past(index) - IDX_W'(1)] ||
                              index == $past(index)));

    // R7: an acknowledge clears at most one flag.
    a_r7_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));

    // R10: no clear without an offer.
    a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (clr == '0));
endmodule

// File: rtl/prio_vec_intc.sv
// Module: top of the fixed-priority vectored interrupt controller.
// It joins the enable registers, the pending flags and the selector.
// The CPU is assumed to hold irq_ack for one cycle per accepted interrupt.
module prio_vec_intc
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               irq_ack,
    output logic               irq_valid,
    output logic [IDX_W-1:0]   irq_index,
    output logic [VEC_W-1:0]   irq_vector
);
    logic               glb_en;
    logic [NUM_SRC-1:0] src_en;
    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] clr;

    intc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .glb_en(glb_en), .src_en(src_en)
    );

    intc_pending u_pend (
        .clk(clk), .rst_n(rst_n), .req(req), .clr(clr), .pending(pending)
    );

    intc_select u_sel (
        .clk(clk), .rst_n(rst_n), .pending(pending), .src_en(src_en),
        .glb_en(glb_en), .ack(irq_ack), .valid(irq_valid),
        .index(irq_index), .vector(irq_vector), .clr(clr)
    );

    // R5: the vector field pattern agrees with the offered number.
    a_r5_vector_form: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vector[2:0] == 3'd3 &&
                       (irq_vector >> 3) == VEC_W'(irq_index - IDX_W'(1))));
endmodule

// File: tb/prio_vec_intc_test.sv
// Scoreboard bench: the driver pushes expected items; a monitor at the
// falling edge pops and compares them.
module prio_vec_intc_test;
    import intc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_SRC-1:0] req = '0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic irq_ack = 1'b0;
    logic irq_valid;
    logic [IDX_W-1:0] irq_index;
    logic [VEC_W-1:0] irq_vector;

    typedef struct {
        bit          is_rd;
        bit          v;
        int          idx;
        int          data;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prio_vec_intc uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_index(irq_index),
        .irq_vector(irq_vector)
    );

    // Monitor: compare every queued expectation at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (it.is_rd) begin
                if (int'(rd_data) != it.data) begin
                    n_bad++;
                    $display("FAIL %s rd_data=%0h exp=%0h", it.tag, rd_data, it.data);
                end
            end else begin
                int ev;
                ev = it.v ? 3 + 8 * (it.idx - 1) : 0;
                if (irq_valid != it.v || int'(irq_index) != (it.v ? it.idx : 0) ||
                    int'(irq_vector) != ev) begin
                    n_bad++;
                    $display("FAIL %s valid/index/vector=%0d/%0d/%0h exp=%0d/%0d/%0h",
                             it.tag, irq_valid, irq_index, irq_vector,
                             it.v, it.v ? it.idx : 0, ev);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic exp_out(bit v, int idx, string tag);
        item_t it;
        it.is_rd = 1'b0; it.v = v; it.idx = idx; it.data = 0; it.tag = tag;
        sb.push_back(it);
        settle();
    endtask

    task automatic exp_rd(int a, int d, string tag);
        item_t it;
        rd_addr = ADDR_W'(a);
        it.is_rd = 1'b1; it.v = 1'b0; it.idx = 0; it.data = d; it.tag = tag;
        sb.push_back(it);
        settle();
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse(int src);
        req = '0;
        req[src - 1] = 1'b1;
        step();
        req = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1: reset state
        exp_out(1'b0, 0, "R1 idle after reset");
        for (int a = 0; a < 5; a++) exp_rd(a, 0, "R1 register cleared");

        // R9: register port map
        wr(1, 'hFF);  exp_rd(1, 'h3F, "R9 group width");
        wr(5, 'hFF);  exp_rd(5, 0, "R9 undecoded read");
        exp_rd(1, 'h3F, "R9 undecoded write ignored");
        wr(0, 'hFF);  exp_rd(0, 1, "R9 global enable bit");
        wr(0, 0); wr(1, 0);

        // R2/R3: latch while disabled, offer only when both enables set
        pulse(5);     exp_out(1'b0, 0, "R3 all disabled");
        wr(1, 'h10);  exp_out(1'b0, 0, "R3 global off");
        wr(0, 1);     exp_out(1'b1, 5, "R2 latched flag offered");
        ack();        exp_out(1'b0, 0, "R7 cleared after ack");

        // R4/R6/R7: priority, hold, next offer
        for (int a = 1; a < 5; a++) wr(a, 'h3F);
        req = '0; req[20] = 1'b1; req[9] = 1'b1; step(); req = '0;
        exp_out(1'b1, 10, "R4 lowest number wins");
        ack();        exp_out(1'b1, 21, "R7 next source offered");
        pulse(1);     exp_out(1'b1, 21, "R6 held against higher priority");
        ack();        exp_out(1'b1, 1, "R7 held source cleared");
        ack();        exp_out(1'b0, 0, "R7 all served");

        // R8: set wins over clear
        pulse(3);     exp_out(1'b1, 3, "R5 source 3 vector");
        req[2] = 1'b1; irq_ack = 1'b1; step(); req = '0; irq_ack = 1'b0;
        exp_out(1'b1, 3, "R8 request kept");
        ack();        exp_out(1'b0, 0, "R8 then cleared");

        // R10: idle acknowledge
        wr(2, 0);
        pulse(7);     exp_out(1'b0, 0, "R3 group bit off");
        ack();
        wr(2, 1);     exp_out(1'b1, 7, "R10 flag survived idle ack");
        ack();        exp_out(1'b0, 0, "R7 source 7 served");

        // R5: highest source vector
        pulse(24);    exp_out(1'b1, 24, "R5 source 24 vector");
        ack();

        // R3: global enable withdrawn during offer
        pulse(13);    exp_out(1'b1, 13, "R5 source 13 vector");
        wr(0, 0);     exp_out(1'b0, 0, "R3 global withdrawn");
        wr(0, 1);     exp_out(1'b1, 13, "R3 global restored");
        ack();        exp_out(1'b0, 0, "R7 source 13 served");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule